// File: doc/BRIEF.md
# Sequential Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands, each given as a sign bit, an unsigned fractional mantissa and an unsigned biased exponent. One operation starts with a single-cycle `start` pulse while the unit is idle. At that pulse the unit captures both operands and the operation select. It then works through a fixed sequence of steps. First it checks for zero mantissas. It then equalises the exponents by shifting the mantissa of the smaller operand right one bit per cycle. It combines the magnitudes using signed-magnitude rules, and finally shifts the result left one bit per cycle until it is normalized.

The result sits on the `res_*` outputs and is valid in the cycle where `done` pulses. It then stays stable until the next accepted `start`. Bits shifted out during alignment are dropped. There is no rounding. A single flag reports that the exponent wrapped past either end of its range.

Top module: `fpas_unit`

## Requirements
- R1: After reset, `busy`, `done`, `res_sign`, `res_mant`, `res_exp` and `exp_wrap` are all 0.
- R2: When the second operand's mantissa is zero, the result is the first operand with its sign, mantissa and exponent unchanged, whatever the operation.
- R3: When the first operand's mantissa is zero and the second's is not, the result is the second operand. Its sign is inverted when `sub_op` = 1 (subtract) and kept when `sub_op` = 0 (add).
- R4: Before combining, the operand with the smaller exponent has its mantissa shifted right once per exponent step until both exponents are equal. The shifted-out bits are discarded.
- R5: When the effective signs match (the second sign is XORed with `sub_op`), the magnitudes are added. A carry out of the MSB shifts the sum right with the carry entering the MSB, and the exponent is incremented.
- R6: When the effective signs differ, the result magnitude is |A − B| of the aligned mantissas. The sign is the first operand's sign if A ≥ B, and its inverse otherwise.
- R7: A computed mantissa of zero gives an all-zero result: sign 0, mantissa 0, exponent 0.
- R8: A nonzero computed result is normalized: mantissa MSB = 1, with the exponent decremented once per left shift.
- R9: `exp_wrap` is set when the exponent is incremented past all-ones or decremented below zero. The exponent then wraps modulo 2^EXP_W. The flag is cleared when a new operation is accepted.
- R10: `start` is accepted only while `busy` = 0. `busy` stays 1 from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse, and a `start` while `busy` = 1 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin an operation (sampled while idle) |
| sub_op | input | 1 | 1 = subtract, 0 = add |
| a_sign | input | 1 | First operand sign |
| a_mant | input | MANT_W | First operand mantissa (fraction) |
| a_exp | input | EXP_W | First operand biased exponent |
| b_sign | input | 1 | Second operand sign |
| b_mant | input | MANT_W | Second operand mantissa |
| b_exp | input | EXP_W | Second operand biased exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| res_sign | output | 1 | Result sign |
| res_mant | output | MANT_W | Result mantissa |
| res_exp | output | EXP_W | Result exponent |
| exp_wrap | output | 1 | Exponent wrapped during this operation |

## Verification
The hardest outcome to reach from the ports is exact cancellation. It needs equal aligned magnitudes with opposite effective signs, and random normalized operands almost never produce it. The stimulus therefore builds a dedicated batch where the second operand is a copy of the first, with the operation chosen so that the effective signs differ. It adds near-equal operands with exponents within a few steps of each other, so that normalization takes long left-shift runs. Exponent wrap in both directions is forced with directed operands at the ends of the exponent range.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_ALIGN = 3'd2,
    S_ADD   = 3'd3,
    S_NORM  = 3'd4,
    S_DONE  = 3'd5
  } state_e;
endpackage

// File: rtl/fpas_exp_cmp.sv
module fpas_exp_cmp #(
  parameter int EXP_W = 6
) (
  input  logic [EXP_W-1:0] exp_x,
  input  logic [EXP_W-1:0] exp_y,
  output logic             x_lt_y,
  output logic             x_gt_y
);
  always_comb begin
    x_lt_y = (exp_x < exp_y);
    x_gt_y = (exp_x > exp_y);
  end
endmodule

// File: rtl/fpas_mant_alu.sv
module fpas_mant_alu #(
  parameter int MANT_W = 8
) (
  input  logic              x_sign,
  input  logic [MANT_W-1:0] x_mant,
  input  logic              y_sign,
  input  logic [MANT_W-1:0] y_mant,
  output logic              out_sign,
  output logic [MANT_W-1:0] out_mant,
  output logic              exp_inc
);
  localparam logic [MANT_W:0]   ONE_W = {{MANT_W{1'b0}}, 1'b1};
  localparam logic [MANT_W-1:0] ONE_M = {{(MANT_W-1){1'b0}}, 1'b1};

  logic           same_sign;
  logic [MANT_W:0] add_w;
  logic [MANT_W:0] sub_w;

  always_comb begin
    same_sign = (x_sign == y_sign);
    add_w     = {1'b0, x_mant} + {1'b0, y_mant};
    sub_w     = {1'b0, x_mant} + {1'b0, ~y_mant} + ONE_W;
    out_sign  = x_sign;
    out_mant  = x_mant;
    exp_inc   = 1'b0;
    if (same_sign) begin
      if (add_w[MANT_W]) begin
        out_mant = add_w[MANT_W:1];
        exp_inc  = 1'b1;
      end else begin
        out_mant = add_w[MANT_W-1:0];
      end
    end else begin
      if (sub_w[MANT_W]) begin
        out_mant = sub_w[MANT_W-1:0];
      end else begin
        out_mant = (~sub_w[MANT_W-1:0]) + ONE_M;
        out_sign = ~x_sign;
      end
    end
  end
endmodule

// File: rtl/fpas_ctrl.sv
module fpas_ctrl
  import fpas_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   x_zero,
  input  logic   y_zero,
  input  logic   x_lt_y,
  input  logic   x_gt_y,
  input  logic   acc_zero,
  input  logic   acc_msb,
  output state_e state_q
);
  state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_CHECK;
      S_CHECK: state_d = (x_zero || y_zero) ? S_DONE : S_ALIGN;
      S_ALIGN: if (!x_lt_y && !x_gt_y) state_d = S_ADD;
      S_ADD:   state_d = S_NORM;
      S_NORM:  if (acc_zero || acc_msb) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/fpas_unit.sv
module fpas_unit
  import fpas_pkg::*;
#(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sub_op,
  input  logic              a_sign,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              b_sign,
  input  logic [MANT_W-1:0] b_mant,
  input  logic [EXP_W-1:0]  b_exp,
  output logic              busy,
  output logic              done,
  output logic              res_sign,
  output logic [MANT_W-1:0] res_mant,
  output logic [EXP_W-1:0]  res_exp,
  output logic              exp_wrap
);
  localparam logic [EXP_W-1:0] EXP_ONE = {{(EXP_W-1){1'b0}}, 1'b1};
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  state_e state_q;

  // working registers: X accumulates the result, Y is the other operand
  logic              xs_q, xs_d, ys_q, ys_d;
  logic [MANT_W-1:0] xm_q, xm_d, ym_q, ym_d;
  logic [EXP_W-1:0]  xe_q, xe_d, ye_q, ye_d;
  logic              wrap_q, wrap_d;
  logic              x_en, y_en;

  logic x_lt_y, x_gt_y;
  logic alu_sign, alu_inc;
  logic [MANT_W-1:0] alu_mant;
  logic x_zero, y_zero;

  assign x_zero = (xm_q == '0);
  assign y_zero = (ym_q == '0);

  fpas_exp_cmp #(.EXP_W(EXP_W)) u_cmp (
    .exp_x (xe_q),
    .exp_y (ye_q),
    .x_lt_y(x_lt_y),
    .x_gt_y(x_gt_y)
  );

  fpas_mant_alu #(.MANT_W(MANT_W)) u_alu (
    .x_sign  (xs_q),
    .x_mant  (xm_q),
    .y_sign  (ys_q),
    .y_mant  (ym_q),
    .out_sign(alu_sign),
    .out_mant(alu_mant),
    .exp_inc (alu_inc)
  );

  fpas_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .x_zero  (x_zero),
    .y_zero  (y_zero),
    .x_lt_y  (x_lt_y),
    .x_gt_y  (x_gt_y),
    .acc_zero(x_zero),
    .acc_msb (xm_q[MANT_W-1]),
    .state_q (state_q)
  );

  // next-state datapath
  always_comb begin
    xs_d = xs_q; xm_d = xm_q; xe_d = xe_q;
    ys_d = ys_q; ym_d = ym_q; ye_d = ye_q;
    wrap_d = wrap_q;
    x_en = 1'b0;
    y_en = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          x_en = 1'b1; y_en = 1'b1;
          xs_d = a_sign; xm_d = a_mant; xe_d = a_exp;
          ys_d = b_sign ^ sub_op; ym_d = b_mant; ye_d = b_exp;
          wrap_d = 1'b0;
        end
      end
      S_CHECK: begin
        if (x_zero && !y_zero) begin
          x_en = 1'b1;
          xs_d = ys_q; xm_d = ym_q; xe_d = ye_q;
        end
      end
      S_ALIGN: begin
        if (x_lt_y) begin
          x_en = 1'b1;
          xm_d = xm_q >> 1;
          xe_d = xe_q + EXP_ONE;
        end else if (x_gt_y) begin
          y_en = 1'b1;
          ym_d = ym_q >> 1;
          ye_d = ye_q + EXP_ONE;
        end
      end
      S_ADD: begin
        x_en = 1'b1;
        xs_d = alu_sign;
        xm_d = alu_mant;
        if (alu_inc) begin
          xe_d = xe_q + EXP_ONE;
          if (xe_q == EXP_MAX) wrap_d = 1'b1;
        end
      end
      S_NORM: begin
        if (x_zero) begin
          x_en = 1'b1;
          xs_d = 1'b0; xe_d = '0;
        end else if (!xm_q[MANT_W-1]) begin
          x_en = 1'b1;
          xm_d = xm_q << 1;
          xe_d = xe_q - EXP_ONE;
          if (xe_q == '0) wrap_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      xs_q <= 1'b0; xm_q <= '0; xe_q <= '0;
      ys_q <= 1'b0; ym_q <= '0; ye_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (x_en) begin
        xs_q <= xs_d; xm_q <= xm_d; xe_q <= xe_d;
      end
      if (y_en) begin
        ys_q <= ys_d; ym_q <= ym_d; ye_q <= ye_d;
      end
      wrap_q <= wrap_d;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_DONE);
  assign res_sign = xs_q;
  assign res_mant = xm_q;
  assign res_exp  = xe_q;
  assign exp_wrap = wrap_q;
endmodule

// File: rtl/fpas_unit_chk.sv
module fpas_unit_chk
  import fpas_pkg::*;
#(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              res_sign,
  input logic [MANT_W-1:0] res_mant,
  input logic [EXP_W-1:0]  res_exp,
  input state_e            state_q,
  input logic [EXP_W-1:0]  xe_q,
  input logic [EXP_W-1:0]  ye_q
);
  // R10: done lasts exactly one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done only occurs inside a busy window
  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R10: an idle start is taken up on the next edge
  a_r10_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R4: combining only happens on equal exponents
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADD) |-> (xe_q == ye_q));

  // R7 / R8: leaving normalization gives a normalized value or a clean zero
  a_r8_norm_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q == S_NORM) && done) |->
      (res_mant[MANT_W-1] || (res_mant == '0 && res_exp == '0 && !res_sign)));
endmodule

bind fpas_unit fpas_unit_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .res_sign(res_sign),
  .res_mant(res_mant),
  .res_exp (res_exp),
  .state_q (state_q),
  .xe_q    (xe_q),
  .ye_q    (ye_q)
);

// File: tb/fpas_unit_tb.sv
module fpas_unit_tb;
  localparam int MW = 8;
  localparam int EW = 6;
  localparam int RW = 2 + EW + MW;

  logic clk, rst_n, start, sub_op;
  logic a_sign, b_sign;
  logic [MW-1:0] a_mant, b_mant;
  logic [EW-1:0] a_exp, b_exp;
  logic busy, done, res_sign, exp_wrap;
  logic [MW-1:0] res_mant;
  logic [EW-1:0] res_exp;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  fpas_unit #(.MANT_W(MW), .EXP_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sub_op(sub_op),
    .a_sign(a_sign), .a_mant(a_mant), .a_exp(a_exp),
    .b_sign(b_sign), .b_mant(b_mant), .b_exp(b_exp),
    .busy(busy), .done(done), .res_sign(res_sign),
    .res_mant(res_mant), .res_exp(res_exp), .exp_wrap(exp_wrap)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // expected result {wrap, sign, exp, mant} from the requirements
  function automatic logic [RW-1:0] model(input logic as_, input int am,
      input int ae, input logic bs, input int bm, input int be, input logic sub);
    logic es, rs, fl;
    int m, e, s;
    es = bs ^ sub;
    fl = 0;
    if (bm == 0) return {1'b0, as_, ae[EW-1:0], am[MW-1:0]};
    if (am == 0) return {1'b0, es, be[EW-1:0], bm[MW-1:0]};
    while (ae < be) begin am = am >> 1; ae++; end
    while (be < ae) begin bm = bm >> 1; be++; end
    e = ae;
    if (as_ == es) begin
      rs = as_;
      s = am + bm;
      if (s >= (1 << MW)) begin
        m = s >> 1;
        e++;
        if (e == (1 << EW)) begin e = 0; fl = 1; end
      end else m = s;
    end else begin
      s = am - bm;
      if (s >= 0) begin m = s; rs = as_; end
      else begin m = -s; rs = ~as_; end
    end
    if (m == 0) return '0;
    while (m < (1 << (MW - 1))) begin
      m = m << 1;
      if (e == 0) begin e = (1 << EW) - 1; fl = 1; end
      else e--;
    end
    return {fl, rs, e[EW-1:0], m[MW-1:0]};
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run_op(input string req, input logic as_, input int am,
      input int ae, input logic bs, input int bm, input int be,
      input logic sub, input bit poke_busy);
    logic [RW-1:0] exp_v;
    exp_v = model(as_, am, ae, bs, bm, be, sub);
    @(negedge clk);
    a_sign = as_; a_mant = am[MW-1:0]; a_exp = ae[EW-1:0];
    b_sign = bs;  b_mant = bm[MW-1:0]; b_exp = be[EW-1:0];
    sub_op = sub; start = 1;
    @(negedge clk);
    start = 0;
    if (poke_busy) begin
      // R10: a second start while busy must not disturb the result
      a_mant = ~a_mant; b_mant = 8'h00; sub_op = ~sub_op; a_sign = ~a_sign;
      start = busy;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    check(req, {exp_wrap, res_sign, res_exp, res_mant}, exp_v);
    @(negedge clk);
    check("R10 done pulse", {{(RW-2){1'b0}}, done, busy}, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int am, ae, bm, be;
    logic as_, bs, sb;
    void'($urandom(32'h1a2b));
    rst_n = 0; start = 0; sub_op = 0;
    a_sign = 0; a_mant = '0; a_exp = '0;
    b_sign = 0; b_mant = '0; b_exp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    check("R1 reset", {exp_wrap, res_sign, res_exp, res_mant}, '0);
    check("R1 reset hs", {{(RW-2){1'b0}}, busy, done}, '0);

    // R2: zero second operand, unnormalized first kept as is
    run_op("R2 b zero", 1, 8'h15, 9, 0, 0, 40, 1, 0);
    run_op("R2 both zero", 1, 0, 17, 1, 0, 3, 0, 0);
    // R3: zero first operand
    run_op("R3 a zero sub", 0, 0, 5, 0, 8'hA0, 22, 1, 0);
    run_op("R3 a zero add", 0, 0, 5, 1, 8'h31, 22, 0, 0);
    // R4: alignment with truncation
    run_op("R4 align a small", 0, 8'hFF, 10, 0, 8'h80, 14, 0, 0);
    run_op("R4 align b small", 0, 8'h81, 30, 0, 8'hFF, 24, 0, 0);
    // R5: carry out
    run_op("R5 carry", 0, 8'hC0, 20, 0, 8'hC0, 20, 0, 0);
    // R6: sign of larger magnitude
    run_op("R6 b larger", 0, 8'h90, 12, 0, 8'hF0, 12, 1, 0);
    run_op("R6 a larger", 1, 8'hF0, 12, 0, 8'h90, 12, 0, 0);
    // R7: exact cancellation
    run_op("R7 cancel", 1, 8'hB3, 33, 1, 8'hB3, 33, 1, 0);
    // R8: long normalization
    run_op("R8 norm", 0, 8'h81, 40, 0, 8'h80, 40, 1, 0);
    // R9: exponent wrap both ways
    run_op("R9 wrap up", 0, 8'h80, 63, 0, 8'h80, 63, 0, 0);
    run_op("R9 wrap down", 0, 8'h80, 0, 0, 8'hC0, 0, 1, 0);
    // R10: start while busy ignored
    run_op("R10 busy start", 0, 8'hA5, 20, 1, 8'h9C, 18, 0, 1);

    // random normalized operands (R4 R5 R6 R8)
    for (int i = 0; i < 300; i++) begin
      as_ = 1'($urandom); bs = 1'($urandom); sb = 1'($urandom);
      am = 128 + int'($urandom % 128); bm = 128 + int'($urandom % 128);
      ae = int'($urandom % 64);
      if (i % 2 == 0) be = int'($urandom % 64);
      else begin
        be = ae + int'($urandom % 4);
        if (be > 63) be = 63;
      end
      run_op("R6 random", as_, am, ae, bs, bm, be, sb, 0);
    end
    // random exact cancellation (R7)
    for (int i = 0; i < 40; i++) begin
      as_ = 1'($urandom); sb = 1'($urandom);
      am = 128 + int'($urandom % 128); ae = int'($urandom % 64);
      run_op("R7 random cancel", as_, am, ae, as_ ^ ~sb, am, ae, sb, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule